// File: doc/BRIEF.md
# Eight-Channel DAC Command Register Decoder

This block sits behind a serial receiver and in front of eight converter channels. It accepts one fully assembled 16-bit command word per strobe. It sorts each word into a per-channel holding register, one of two configuration registers, or a preset register. It also controls when the holding values reach the codes driven toward the converters.

Two active-low asynchronous controls act on the outputs. The load input is level sensitive: while it is asserted, the output latches follow the holding registers every cycle. While the preset input is asserted, every channel output is forced to the stored preset code. Both controls pass through a two-flop synchronizer before use. The resolution parameter clears the low data bits that a narrower converter would not decode.

Top module: `mcdac_cmd_decoder`

## Requirements
- R1: A word whose bits 15:12 hold a value from 0 to 7 writes data bits 11:0 into the holding register of the channel with that index, where channel 0 is A and channel 7 is H. The holding register updates on the clock edge that samples the strobe.
- R2: A word with address 11 changes no holding register, no configuration register and no preset value.
- R3: Addresses 12, 13, 14 and 15 are pair writes to channel pairs 0/1, 2/3, 4/5 and 6/7. The even channel receives the data, and the odd channel receives the bitwise inverse of that data.
- R4: Address 8 writes configuration word 0. Data bit 4 drives `pd_all`, bit 3 drives `cascade_en`, bits 2:1 drive `ref_sel` (0 and 1 external, 2 internal low, 3 internal high), and bit 0 enables two's-complement input. Data bits 11:5 are ignored.
- R5: Address 9 writes configuration word 1. Data bits 7:4 drive `pair_pd[3:0]` and data bits 3:0 drive `pair_fast[3:0]`. In both fields, bit index 0 is pair A/B and bit index 3 is pair G/H. A 1 in `pair_fast` means fast. Data bits 11:8 are ignored.
- R6: While two's-complement input is enabled, channel data is converted to offset binary by inverting bit 11 before it is stored. In a pair write, the odd channel receives the inverse of the converted value. Writes to the preset register are never converted.
- R7: When `RES_BITS` is 10, data bits 1:0 of every stored channel and preset value are zero. When `RES_BITS` is 8, data bits 3:0 are zero. When `RES_BITS` is 12, all bits are kept.
- R8: `load_n` passes through a two-stage synchronizer. While the synchronized level is low, each output latch copies its holding register on every edge, and the registered output code follows one edge later. While the synchronized level is high, the output latches keep their values.
- R9: Address 10 writes the preset value. While the synchronized `preset_n` is low, every channel code equals the preset value, one edge after the synchronizer. When `preset_n` is released, the channel codes return to the output latch contents.
- R10: A synchronous active-high reset clears every holding register, output latch, channel code, configuration bit and the preset value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Strobe marking a committed command word |
| cmd_word | input | 16 | Address in bits 15:12, data in bits 11:0 |
| load_n | input | 1 | Asynchronous active-low level transfer of the holding registers to the output latches |
| preset_n | input | 1 | Asynchronous active-low override forcing all channels to the preset value |
| ch_code | output | 96 | Eight 12-bit channel codes, channel i in bits 12*i+11:12*i |
| pd_all | output | 1 | Whole-device power-down flag |
| cascade_en | output | 1 | Enable for the downstream cascade output |
| ref_sel | output | 2 | Reference selection |
| pair_pd | output | 4 | Power-down flag per channel pair |
| pair_fast | output | 4 | Fast settling flag per channel pair |

## Verification
The bench builds two instances side by side. One uses `RES_BITS` = 12, where every data bit is kept. The other uses `RES_BITS` = 8, where the four low bits of every channel and preset value are cleared. The same command stream drives both instances, so one run compares full and reduced resolution. In particular, it covers the case of a pair write under two's-complement mode, where the inverted partner value must still be masked.

// File: rtl/mcdac_pkg.sv
package mcdac_pkg;
  localparam int CH_NUM    = 8;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 12;
  localparam int WORD_W    = ADDR_W + DATA_W;
  localparam int PAIR_NUM  = CH_NUM / 2;
  localparam int CH_IDX_W  = $clog2(CH_NUM);

  localparam logic [ADDR_W-1:0] ADR_CFG0   = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CFG1   = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_PRESET = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_RSVD   = 4'd11;

  typedef struct packed {
    logic       pd_all;
    logic       casc;
    logic [1:0] ref_sel;
    logic       twos;
  } cfg0_t;

  typedef struct packed {
    logic [PAIR_NUM-1:0] pd;
    logic [PAIR_NUM-1:0] fast;
  } cfg1_t;

  function automatic logic is_pair_adr(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ADDR_W-2] == 2'b11;
  endfunction
endpackage

// File: rtl/mcdac_sync.sv
module mcdac_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

  // R8: the last stage only ever takes what the previous stage held
  assert_sync_shift_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> q == $past(chain_q[STAGES-2]));
endmodule

// File: rtl/mcdac_decode.sv
module mcdac_decode
  import mcdac_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                           cmd_valid,
  input  logic [WORD_W-1:0]              cmd_word,
  input  logic                           twos,
  output logic [CH_NUM-1:0]              ch_we,
  output logic [CH_NUM-1:0][DATA_W-1:0]  ch_wdata,
  output logic                           cfg0_we,
  output logic                           cfg1_we,
  output logic                           preset_we,
  output logic [DATA_W-1:0]              preset_wdata
);
  localparam int LOW_DROP = DATA_W - RES_BITS;
  localparam logic [DATA_W-1:0] KEEP_MASK = {DATA_W{1'b1}} << LOW_DROP;

  logic [ADDR_W-1:0] adr;
  logic [DATA_W-1:0] raw, conv, direct_val, inv_val;
  logic              pair_hit;

  always_comb begin
    adr        = cmd_word[WORD_W-1:DATA_W];
    raw        = cmd_word[DATA_W-1:0];
    conv       = raw ^ {twos, {(DATA_W-1){1'b0}}};
    direct_val = conv & KEEP_MASK;
    inv_val    = ~conv & KEEP_MASK;
    pair_hit   = cmd_valid && is_pair_adr(adr);
  end

  for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] OWN_ADR  = ADDR_W'(g);
    localparam logic [1:0]        PAIR_SEL = 2'(g / 2);
    localparam bit                IS_ODD   = (g % 2) == 1;
    always_comb begin
      ch_we[g] = (cmd_valid && adr == OWN_ADR) ||
                 (pair_hit && adr[1:0] == PAIR_SEL);
      if (IS_ODD && is_pair_adr(adr)) ch_wdata[g] = inv_val;
      else                            ch_wdata[g] = direct_val;
    end
  end

  always_comb begin
    cfg0_we      = cmd_valid && adr == ADR_CFG0;
    cfg1_we      = cmd_valid && adr == ADR_CFG1;
    preset_we    = cmd_valid && adr == ADR_PRESET;
    preset_wdata = raw & KEEP_MASK;
  end
endmodule

// File: rtl/mcdac_chan_bank.sv
module mcdac_chan_bank #(
  parameter int N = 8,
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         we,
  input  logic [N-1:0][W-1:0]  wdata,
  input  logic                 ld_act,
  input  logic                 pre_act,
  input  logic [W-1:0]         preset_val,
  output logic [N-1:0][W-1:0]  code_q
);
  logic [N-1:0][W-1:0] hold_q, latch_q;

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q[g]  <= '0;
        latch_q[g] <= '0;
        code_q[g]  <= '0;
      end else begin
        if (we[g])   hold_q[g]  <= wdata[g];
        if (ld_act)  latch_q[g] <= hold_q[g];
        code_q[g] <= pre_act ? preset_val : latch_q[g];
      end
    end

    // R1: a strobed write lands in the holding register
    assert_hold_write_R1: assert property (@(posedge clk) disable iff (rst)
      we[g] |=> hold_q[g] == $past(wdata[g]));
    // R8: latches freeze while the load level is inactive
    assert_latch_freeze_R8: assert property (@(posedge clk) disable iff (rst)
      !ld_act |=> $stable(latch_q[g]));
    // R8: latches follow the holding register while the load level is active
    assert_latch_follow_R8: assert property (@(posedge clk) disable iff (rst)
      ld_act |=> latch_q[g] == $past(hold_q[g]));
    // R9: preset overrides every lane
    assert_preset_force_R9: assert property (@(posedge clk) disable iff (rst)
      pre_act |=> code_q[g] == $past(preset_val));
  end
endmodule

// File: rtl/mcdac_cmd_decoder.sv
module mcdac_cmd_decoder
  import mcdac_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic [15:0]                cmd_word,
  input  logic                       load_n,
  input  logic                       preset_n,
  output logic [CH_NUM*DATA_W-1:0]   ch_code,
  output logic                       pd_all,
  output logic                       cascade_en,
  output logic [1:0]                 ref_sel,
  output logic [PAIR_NUM-1:0]        pair_pd,
  output logic [PAIR_NUM-1:0]        pair_fast
);
  localparam int CFG0_W = $bits(cfg0_t);
  localparam int CFG1_W = $bits(cfg1_t);
  localparam logic [DATA_W-1:0] KEEP_MASK = {DATA_W{1'b1}} << (DATA_W - RES_BITS);

  cfg0_t                          cfg0_q;
  cfg1_t                          cfg1_q;
  logic [DATA_W-1:0]              preset_q;
  logic [CH_NUM-1:0]              ch_we;
  logic [CH_NUM-1:0][DATA_W-1:0]  ch_wdata;
  logic [CH_NUM-1:0][DATA_W-1:0]  code_q;
  logic                           cfg0_we, cfg1_we, preset_we;
  logic [DATA_W-1:0]              preset_wdata;
  logic                           load_s, preset_s;

  mcdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
    .clk(clk), .rst(rst), .d(load_n), .q(load_s));
  mcdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pre (
    .clk(clk), .rst(rst), .d(preset_n), .q(preset_s));

  mcdac_decode #(.RES_BITS(RES_BITS)) u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .twos(cfg0_q.twos),
    .ch_we(ch_we), .ch_wdata(ch_wdata),
    .cfg0_we(cfg0_we), .cfg1_we(cfg1_we),
    .preset_we(preset_we), .preset_wdata(preset_wdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg0_q   <= '0;
      cfg1_q   <= '0;
      preset_q <= '0;
    end else begin
      if (cfg0_we)   cfg0_q   <= cfg0_t'(cmd_word[CFG0_W-1:0]);
      if (cfg1_we)   cfg1_q   <= cfg1_t'(cmd_word[CFG1_W-1:0]);
      if (preset_we) preset_q <= preset_wdata;
    end
  end

  mcdac_chan_bank #(.N(CH_NUM), .W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .we(ch_we), .wdata(ch_wdata),
    .ld_act(!load_s), .pre_act(!preset_s),
    .preset_val(preset_q), .code_q(code_q));

  assign ch_code    = code_q;
  assign pd_all     = cfg0_q.pd_all;
  assign cascade_en = cfg0_q.casc;
  assign ref_sel    = cfg0_q.ref_sel;
  assign pair_pd    = cfg1_q.pd;
  assign pair_fast  = cfg1_q.fast;

  // R2: reserved address writes nothing
  assert_rsvd_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[15:12] == ADR_RSVD) |=>
      ($stable(cfg0_q) && $stable(cfg1_q) && $stable(preset_q)));
  assert_rsvd_no_we_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[15:12] == ADR_RSVD) |-> ch_we == '0);
  // R3: a pair write strobes exactly two lanes, with complementary data
  assert_pair_two_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && is_pair_adr(cmd_word[15:12])) |-> $countones(ch_we) == 2);
  assert_pair_inverse_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[15:12] == 4'd12) |->
      ch_wdata[1] == (~ch_wdata[0] & KEEP_MASK));
  // R1: a single-channel write strobes one lane at most
  assert_single_lane_R1: assert property (@(posedge clk) disable iff (rst)
    !is_pair_adr(cmd_word[15:12]) |-> $onehot0(ch_we));
  // R7: dropped low bits stay clear on the channel outputs
  assert_res_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (code_q[0] & ~KEEP_MASK) == '0);
  // R10: the edge after reset leaves everything zero
  assert_reset_clear_R10: assert property (@(posedge clk)
    $past(rst) |-> (ch_code == '0 && cfg0_q == '0 && cfg1_q == '0 && preset_q == '0));
endmodule

// File: tb/mcdac_cmd_decoder_tb.sv
module mcdac_cmd_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic load_n = 1'b0;
  logic preset_n = 1'b1;

  logic [95:0] code0, code1;
  logic pd0, pd1, cas0, cas1;
  logic [1:0] ref0, ref1;
  logic [3:0] ppd0, ppd1, pf0, pf1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mcdac_cmd_decoder #(.RES_BITS(12)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .load_n(load_n), .preset_n(preset_n), .ch_code(code0),
    .pd_all(pd0), .cascade_en(cas0), .ref_sel(ref0),
    .pair_pd(ppd0), .pair_fast(pf0));

  mcdac_cmd_decoder #(.RES_BITS(8)) dut_lo (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .load_n(load_n), .preset_n(preset_n), .ch_code(code1),
    .pd_all(pd1), .cascade_en(cas1), .ref_sel(ref1),
    .pair_pd(ppd1), .pair_fast(pf1));

  // behavioural reference
  int m_hold [2][8];
  int m_latch[2][8];
  int m_out  [2][8];
  int m_pre  [2];
  int m_c0, m_c1;
  int ld1, ld2, pr1, pr2;
  int msk[2] = '{32'hFFF, 32'hFF0};

  always @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < 2; d++) begin
        m_pre[d] = 0;
        for (int i = 0; i < 8; i++) begin
          m_hold[d][i] = 0; m_latch[d][i] = 0; m_out[d][i] = 0;
        end
      end
      m_c0 = 0; m_c1 = 0; ld1 = 1; ld2 = 1; pr1 = 1; pr2 = 1;
    end else begin
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < 8; i++) begin
          m_out[d][i] = (pr2 == 0) ? m_pre[d] : m_latch[d][i];
          if (ld2 == 0) m_latch[d][i] = m_hold[d][i];
        end
      if (cmd_valid) begin
        int a, v, cv;
        a = int'(cmd_word[15:12]);
        v = int'(cmd_word[11:0]);
        cv = ((m_c0 & 1) != 0) ? (v ^ 32'h800) : v;
        for (int d = 0; d < 2; d++) begin
          if (a < 8) m_hold[d][a] = cv & msk[d];
          else if (a >= 12) begin
            m_hold[d][2*(a-12)]   = cv & msk[d];
            m_hold[d][2*(a-12)+1] = (~cv) & msk[d];
          end else if (a == 10) m_pre[d] = v & msk[d];
        end
        if (a == 8) m_c0 = v & 32'h1F;
        if (a == 9) m_c1 = v & 32'hFF;
      end
      ld2 = ld1; ld1 = int'(load_n);
      pr2 = pr1; pr1 = int'(preset_n);
    end
  end

  function automatic int get_code(int d, int i);
    return (d == 0) ? int'(code0[i*12 +: 12]) : int'(code1[i*12 +: 12]);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < 8; i++)
          chk($sformatf("R8 cycle code dut%0d ch%0d", d, i), get_code(d, i), m_out[d][i]);
      chk("R4 cycle pd_all",     int'(pd0),  (m_c0 >> 4) & 1);
      chk("R4 cycle cascade_en", int'(cas0), (m_c0 >> 3) & 1);
      chk("R4 cycle ref_sel",    int'(ref0), (m_c0 >> 1) & 3);
      chk("R5 cycle pair_pd",    int'(ppd0), (m_c1 >> 4) & 15);
      chk("R5 cycle pair_fast",  int'(pf0),  m_c1 & 15);
      chk("R4 cycle lo cfg", int'({pd1, cas1, ref1, ppd1, pf1}),
          int'({pd0, cas0, ref0, ppd0, pf0}));
    end
  end

  task automatic wr(logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    for (int i = 0; i < 8; i++) chk("R10 reset code", get_code(0, i), 0);
    chk("R10 reset cfg", int'({pd0, cas0, ref0, ppd0, pf0}), 0);

    // R1 / R7: plain channel writes
    for (int i = 0; i < 8; i++) wr({4'(i), 12'(12'h0F3 + i * 12'h111)});
    settle(5);
    for (int i = 0; i < 8; i++) begin
      chk("R1 channel write", get_code(0, i), (32'h0F3 + i * 32'h111) & 32'hFFF);
      chk("R7 low bits dropped", get_code(1, i), (32'h0F3 + i * 32'h111) & 32'hFF0);
    end

    // R2: reserved address
    wr(16'hB123);
    settle(5);
    chk("R2 reserved ch0", get_code(0, 0), 32'h0F3);
    chk("R2 reserved ch1", get_code(0, 1), 32'h204);

    // R3: pair write
    wr(16'hC5A3);
    settle(5);
    chk("R3 pair even", get_code(0, 0), 32'h5A3);
    chk("R3 pair odd",  get_code(0, 1), 32'hA5C);
    chk("R7 pair odd masked", get_code(1, 1), 32'hA50);

    // R4: configuration word 0
    wr(16'h801F);
    settle(2);
    chk("R4 all set", int'({pd0, cas0, ref0}), 4'b1111);
    wr(16'h8FE5);
    settle(2);
    chk("R4 upper ignored", int'({pd0, cas0, ref0}), 4'b0010);

    // R6: two's complement (enabled by last word)
    wr(16'h2800);
    wr(16'hD7FF);
    settle(5);
    chk("R6 converted ch2", get_code(0, 2), 32'hFFF);
    chk("R6 converted ch3", get_code(0, 3), 32'h000);
    wr(16'h5000);
    settle(5);
    chk("R6 convert zero", get_code(0, 5), 32'h800);
    wr(16'h8000);

    // R5: configuration word 1
    wr(16'h9F5A);
    settle(2);
    chk("R5 pair_pd", int'(ppd0), 4'b0101);
    chk("R5 pair_fast", int'(pf0), 4'b1010);

    // R8: load held inactive
    @(negedge clk); load_n = 1'b1;
    settle(3);
    wr(16'h4321);
    settle(6);
    chk("R8 frozen ch4", get_code(0, 4), 32'h537);
    @(negedge clk); load_n = 1'b0;
    settle(5);
    chk("R8 released ch4", get_code(0, 4), 32'h321);

    // R9: preset override
    wr(16'hA9C7);
    @(negedge clk); preset_n = 1'b0;
    settle(5);
    for (int i = 0; i < 8; i++) chk("R9 preset forced", get_code(0, i), 32'h9C7);
    chk("R9 preset masked", get_code(1, 6), 32'h9C0);
    @(negedge clk); preset_n = 1'b1;
    settle(5);
    chk("R9 preset released", get_code(0, 0), 32'h5A3);

    // R10: reset mid-run
    @(negedge clk); rst = 1'b1;
    settle(2);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset again code", get_code(0, 4), 0);
    chk("R10 reset again cfg", int'({ppd0, pf0}), 0);
    settle(3);
    finish_run();
  end
endmodule